// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL clock of an I2C master and hands the byte engine a set of single-cycle strobes telling it when to change SDA, when SCL is about to be released, when to sample SDA, and when a START or STOP condition has finished. All bus timing comes from four cycle counts held in configuration registers elsewhere: the full SCL period, the SCL low time, one shared START/STOP setup-and-hold time, and the delay from SCL falling to SDA changing. For 100 kHz or 400 kHz operation the period is the input clock divided by the bus rate, the low time about 5/9 of it, the edge time half of it and the data delay a sixteenth of it.

The byte engine issues one command at a time (a START, one bit, or a STOP) while `ready` is high. After SCL is released, the high phase is counted only once SCL reads back high, so a target that holds SCL low stretches the bit. A recovery override lets software take SCL directly and watch both lines through a four-bit bus monitor.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset SCL is released (`sclOut` = 1), `ready` is 1 and every strobe is 0.
- R2: `cmdKind` encodes 1 = START, 2 = STOP, any other value = one bit. A START accepted in cycle a with SCL high pulses `drvSda` in cycle a+E and `startDone` in a+2E, with E = max(edge count, 2). SCL is low from a+2E+1.
- R3: For a bit, STOP or repeated START accepted in cycle a with SCL low, `drvSda` pulses in cycle a+D, where L = max(low count, 2) and D is the data count raised to at least 1 and limited to at most L-1.
- R4: In that case `sclRise` pulses in cycle a+L-1 and `sclOut` is high from cycle a+L.
- R5: The high phase of a bit lasts H = max(period - L, 2) cycles from the first cycle SCL reads back high; SCL is low and `ready` is 1 from that cycle plus H.
- R6: While SCL is released but reads back low, the block waits; every later event of the command moves by the number of stretched cycles.
- R7: Each bit gives exactly one `sampleSda` pulse, H/2 cycles (rounded down) after SCL first reads back high, while SCL reads high.
- R8: A repeated START issued with SCL low pulses `drvSda` at a+D and again at a+L+S+E-1, and `startDone` at a+L+S+2E-1, where S is the stretch.
- R9: A STOP pulses `drvSda` at a+D and both `drvSda` and `stopDone` at a+L+S+E-1; SCL stays high and `ready` returns the next cycle.
- R10: With `normalOp` = 0, `sclOut` equals `sclRelease`, `ready` is 0, commands are ignored and no strobe fires; with `sclRelease` = 1 at the end, the block resumes ready with SCL high.
- R11: `busMon` bit 3 is the engine's SDA level, bit 2 the SDA readback, bit 1 the SCL output and bit 0 the SCL readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low reset |
| normalOp | input | 1 | 1 = generator drives SCL, 0 = recovery override |
| sclRelease | input | 1 | SCL level during override (1 = released) |
| periodCnt | input | CNT_W | SCL period in clock cycles |
| lowCnt | input | CNT_W | SCL low time in clock cycles |
| edgeCnt | input | CNT_W | START/STOP setup and hold time |
| dataSetupCnt | input | CNT_W | Delay from SCL falling to SDA change |
| cmdValid | input | 1 | Command present, taken when ready |
| cmdKind | input | 2 | Command kind (1 START, 2 STOP, else bit) |
| ready | output | 1 | Block idle and able to take a command |
| sdaLevel | input | 1 | SDA level the byte engine drives |
| sclIn | input | 1 | SCL line readback |
| sdaIn | input | 1 | SDA line readback |
| sclOut | output | 1 | SCL drive (1 = released) |
| drvSda | output | 1 | Strobe: apply next SDA level |
| sclRise | output | 1 | Strobe: SCL released next cycle |
| sampleSda | output | 1 | Strobe: sample SDA now |
| startDone | output | 1 | Strobe: START condition finished |
| stopDone | output | 1 | Strobe: STOP condition finished |
| busMon | output | 4 | Line monitor {SDA out, SDA in, SCL out, SCL in} |

## Verification
The bench builds the block with CNT_W = 7, so every count fits in 0 to 127 and a period at the top of that range, a data delay beyond the low time, zero edge and data counts and a period below the low time plus two all appear among the directed settings beside random ones. Random stretch lengths of up to three cycles on bits and STOPs show that the wait on the readback moves every later strobe by exactly that amount.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

  typedef enum logic [1:0] {
    CMD_BIT   = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAITHI,
    PH_HIGH,
    PH_SETUP,
    PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    CNT_KEEP,
    CNT_CLR,
    CNT_ONE,
    CNT_INC
  } cntop_e;

  // strobes towards the byte engine
  typedef struct packed {
    logic drvSda;
    logic sclRise;
    logic sampleSda;
    logic startDone;
    logic stopDone;
  } strobe_t;

  // compare results from the datapath towards the control
  typedef struct packed {
    logic atData;
    logic lowEnd;
    logic highMid;
    logic highEnd;
    logic edgeEnd;
  } flags_t;

endpackage

// File: rtl/sclt_datapath.sv
module sclt_datapath
  import sclt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] edgeCnt,
  input  logic [CNT_W-1:0] dataSetupCnt,
  input  cntop_e           cntOp,
  output flags_t           flags
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_PH = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] lowEff;
  logic [CNT_W-1:0] lowLast;
  logic [CNT_W-1:0] highEff;
  logic [CNT_W-1:0] dataEff;
  logic [CNT_W-1:0] edgeEff;
  logic [EXT_W-1:0] lowPlusTwo;

  // effective phase lengths after clamping
  always_comb begin
    lowEff     = (lowCnt < MIN_PH) ? MIN_PH : lowCnt;
    lowLast    = lowEff - ONE_C;
    lowPlusTwo = {1'b0, lowEff} + EXT_W'(2);
    highEff    = ({1'b0, periodCnt} >= lowPlusTwo) ? (periodCnt - lowEff) : MIN_PH;
    edgeEff    = (edgeCnt < MIN_PH) ? MIN_PH : edgeCnt;
    if (dataSetupCnt == '0)          dataEff = ONE_C;
    else if (dataSetupCnt > lowLast) dataEff = lowLast;
    else                             dataEff = dataSetupCnt;
  end

  always_comb begin
    flags.atData  = (cntQ == dataEff);
    flags.lowEnd  = (cntQ >= lowLast);
    flags.highMid = (cntQ == (highEff >> 1));
    flags.highEnd = (cntQ >= (highEff - ONE_C));
    flags.edgeEnd = (cntQ >= (edgeEff - ONE_C));
  end

  // phase counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      unique case (cntOp)
        CNT_CLR:  cntQ <= '0;
        CNT_ONE:  cntQ <= ONE_C;
        CNT_INC:  if (cntQ != '1) cntQ <= cntQ + ONE_C;
        default:  cntQ <= cntQ;
      endcase
    end
  end

endmodule

// File: rtl/sclt_control.sv
module sclt_control
  import sclt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       normalOp,
  input  logic       sclRelease,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       sclIn,
  input  flags_t     flags,
  output cntop_e     cntOp,
  output logic       sclQ,
  output logic       ready,
  output strobe_t    stb
);

  phase_e phase, nextPhase;
  cmd_e   target, nextTarget, cmdNorm;
  logic   nextScl;

  always_comb begin
    if (cmdKind == 2'd1)      cmdNorm = CMD_START;
    else if (cmdKind == 2'd2) cmdNorm = CMD_STOP;
    else                      cmdNorm = CMD_BIT;
  end

  always_comb begin
    nextPhase  = phase;
    nextTarget = target;
    nextScl    = sclQ;
    cntOp      = CNT_INC;
    stb        = '0;
    unique case (phase)
      PH_IDLE: begin
        cntOp = CNT_CLR;
        if (cmdValid) begin
          nextTarget = cmdNorm;
          if (cmdNorm == CMD_BIT || !sclQ) begin
            // the accept cycle already counts as the first low cycle
            nextPhase = PH_LOW;
            nextScl   = 1'b0;
            cntOp     = CNT_ONE;
          end else begin
            nextPhase = PH_SETUP;
          end
        end
      end
      PH_LOW: begin
        stb.drvSda = flags.atData;
        if (flags.lowEnd) begin
          stb.sclRise = 1'b1;
          nextScl     = 1'b1;
          nextPhase   = PH_WAITHI;
        end
      end
      PH_WAITHI: begin
        cntOp = CNT_KEEP;
        if (sclIn) begin
          // first cycle seen high is count zero of the high phase
          cntOp     = CNT_ONE;
          nextPhase = (target == CMD_BIT) ? PH_HIGH : PH_SETUP;
        end
      end
      PH_HIGH: begin
        stb.sampleSda = flags.highMid;
        if (flags.highEnd) begin
          nextScl   = 1'b0;
          nextPhase = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (flags.edgeEnd) begin
          stb.drvSda = 1'b1;
          if (target == CMD_START) begin
            nextPhase = PH_HOLD;
            cntOp     = CNT_CLR;
          end else begin
            stb.stopDone = 1'b1;
            nextPhase    = PH_IDLE;
          end
        end
      end
      PH_HOLD: begin
        if (flags.edgeEnd) begin
          stb.startDone = 1'b1;
          nextScl       = 1'b0;
          nextPhase     = PH_IDLE;
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
    if (!normalOp) begin
      nextPhase = PH_IDLE;
      nextScl   = sclRelease;
      cntOp     = CNT_CLR;
      stb       = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      target <= CMD_BIT;
      sclQ   <= 1'b1;
    end else begin
      phase  <= nextPhase;
      target <= nextTarget;
      sclQ   <= nextScl;
    end
  end

  assign ready = normalOp && (phase == PH_IDLE);

  // R4: a release strobe is followed by SCL high
  p_rise_r4: assert property (@(posedge clk) disable iff (!rstN || !normalOp)
    stb.sclRise |=> sclQ);

  // R7: sampling only while SCL is driven and read back high
  p_sample_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleSda |-> (sclIn && sclQ));

  // R6: a stretched clock holds the wait phase
  p_wait_r6: assert property (@(posedge clk) disable iff (!rstN || !normalOp)
    (phase == PH_WAITHI && !sclIn) |=> (phase == PH_WAITHI));

  // R2: SCL goes low right after START completes
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN || !normalOp)
    stb.startDone |=> !sclQ);

  // R9: STOP completes with SCL high
  p_stop_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopDone |-> sclQ);

  // R10: override forces the idle phase
  p_override_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !normalOp |=> (phase == PH_IDLE));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import sclt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             normalOp,
  input  logic             sclRelease,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] edgeCnt,
  input  logic [CNT_W-1:0] dataSetupCnt,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  output logic             ready,
  input  logic             sdaLevel,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             drvSda,
  output logic             sclRise,
  output logic             sampleSda,
  output logic             startDone,
  output logic             stopDone,
  output logic [3:0]       busMon
);

  flags_t  flags;
  cntop_e  cntOp;
  strobe_t stb;
  logic    sclQ;

  sclt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .periodCnt    (periodCnt),
    .lowCnt       (lowCnt),
    .edgeCnt      (edgeCnt),
    .dataSetupCnt (dataSetupCnt),
    .cntOp        (cntOp),
    .flags        (flags)
  );

  sclt_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .normalOp   (normalOp),
    .sclRelease (sclRelease),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .sclIn      (sclIn),
    .flags      (flags),
    .cntOp      (cntOp),
    .sclQ       (sclQ),
    .ready      (ready),
    .stb        (stb)
  );

  assign sclOut    = normalOp ? sclQ : sclRelease;
  assign drvSda    = stb.drvSda;
  assign sclRise   = stb.sclRise;
  assign sampleSda = stb.sampleSda;
  assign startDone = stb.startDone;
  assign stopDone  = stb.stopDone;
  assign busMon    = {sdaLevel, sdaIn, sclOut, sclIn};

endmodule

// File: tb/tb_i2c_scl_timer.sv
`timescale 1ns/1ps
module tb_i2c_scl_timer;

  localparam int CW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic normalOp = 1'b1, sclRelease = 1'b1;
  logic [CW-1:0] periodCnt = CW'(20), lowCnt = CW'(11), edgeCnt = CW'(10), dataSetupCnt = CW'(2);
  logic cmdValid = 1'b0;
  logic [1:0] cmdKind = 2'd0;
  logic sdaLevel = 1'b1, sdaOther = 1'b1;
  logic stretchOn = 1'b0;
  logic ready, sclOut, drvSda, sclRise, sampleSda, startDone, stopDone, sclIn, sdaIn;
  logic [3:0] busMon;

  assign sclIn = sclOut & ~stretchOn;
  assign sdaIn = sdaLevel & sdaOther;

  always #2.5 clk = ~clk;

  i2c_scl_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .normalOp(normalOp), .sclRelease(sclRelease),
    .periodCnt(periodCnt), .lowCnt(lowCnt), .edgeCnt(edgeCnt), .dataSetupCnt(dataSetupCnt),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .ready(ready), .sdaLevel(sdaLevel),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclOut(sclOut), .drvSda(drvSda), .sclRise(sclRise),
    .sampleSda(sampleSda), .startDone(startDone), .stopDone(stopDone), .busMon(busMon)
  );

  int total = 0, fails = 0;
  bit done = 1'b0;
  int nDrv, nRise, nSample, nStart, nStop;
  int tDrv0, tDrv1, tRise, tSample, tStart, tStop, tInRise, tOutFall;
  int stretchLen = 0, stretchCnt = 0;
  logic prevSclIn = 1'b1, prevSclOut = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cyc();
    return int'(($time - 1) / 5);
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // event log, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      int c;
      c = int'($time / 5);
      if (drvSda) begin
        if (nDrv == 0) tDrv0 = c; else tDrv1 = c;
        nDrv++;
      end
      if (sclRise)   begin tRise = c; nRise++; end
      if (sampleSda) begin tSample = c; nSample++; end
      if (startDone) begin tStart = c; nStart++; end
      if (stopDone)  begin tStop = c; nStop++; end
      if (sclIn && !prevSclIn)   tInRise = c;
      if (!sclOut && prevSclOut) tOutFall = c;
      prevSclIn  = sclIn;
      prevSclOut = sclOut;
    end
  end

  // target clock stretching, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    if (stretchOn && sclOut) begin
      if (stretchCnt == stretchLen) stretchOn = 1'b0;
      else stretchCnt++;
    end
  end

  function automatic int fLow(input int l);  return (l < 2) ? 2 : l; endfunction
  function automatic int fHigh(input int p, input int l);
    return (p >= fLow(l) + 2) ? p - fLow(l) : 2;
  endfunction
  function automatic int fData(input int d, input int l);
    if (d == 0) return 1;
    if (d > fLow(l) - 1) return fLow(l) - 1;
    return d;
  endfunction
  function automatic int fEdge(input int e); return (e < 2) ? 2 : e; endfunction

  task automatic clearLog();
    nDrv = 0; nRise = 0; nSample = 0; nStart = 0; nStop = 0;
    tDrv0 = -1; tDrv1 = -1; tRise = -1; tSample = -1; tStart = -1; tStop = -1;
    tInRise = -1; tOutFall = -1;
  endtask

  task automatic runCmd(input logic [1:0] k, input int s, output int a, output int r);
    while (!ready) tick();
    clearLog();
    stretchLen = s; stretchCnt = 0; stretchOn = (s > 0);
    cmdValid = 1'b1; cmdKind = k; a = cyc();
    tick();
    cmdValid = 1'b0;
    while (!ready) tick();
    r = cyc();
  endtask

  int L, H, D, E;

  task automatic doStartIdle();
    int a, r;
    runCmd(2'd1, 0, a, r);
    check("R2 start drvSda", tDrv0, a + E);
    check("R2 start done", tStart, a + 2 * E);
    check("R2 start drv count", nDrv, 1);
    check("R2 scl low after start", int'(sclOut), 0);
  endtask

  task automatic doBit(input int s, input logic [1:0] k);
    int a, r;
    runCmd(k, s, a, r);
    check("R3 bit data strobe", tDrv0, a + D);
    check("R4 bit release strobe", tRise, a + L - 1);
    check("R7 bit sample point", tSample, a + L + s + H / 2);
    check("R7 one sample", nSample, 1);
    check("R5 high length", tOutFall - tInRise, H);
    if (s > 0) check("R6 stretched end", r, a + L + s + H);
    else       check("R5 bit end", r, a + L + H);
  endtask

  task automatic doRestart(input int s);
    int a, r;
    runCmd(2'd1, s, a, r);
    check("R8 restart release drv", tDrv0, a + D);
    check("R8 restart low drv", tDrv1, a + L + s + E - 1);
    check("R8 restart done", tStart, a + L + s + 2 * E - 1);
    check("R8 restart drv count", nDrv, 2);
  endtask

  task automatic doStop(input int s);
    int a, r;
    runCmd(2'd2, s, a, r);
    check("R9 stop first drv", tDrv0, a + D);
    check("R9 stop done", tStop, a + L + s + E - 1);
    check("R9 stop final drv", tDrv1, a + L + s + E - 1);
    check("R9 ready after stop", r, a + L + s + E);
    check("R9 scl high after stop", int'(sclOut), 1);
  endtask

  task automatic setCfg(input int p, input int l, input int e, input int d);
    periodCnt = CW'(p); lowCnt = CW'(l); edgeCnt = CW'(e); dataSetupCnt = CW'(d);
    L = fLow(l); H = fHigh(p, l); D = fData(d, l); E = fEdge(e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd9127);
    clearLog();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 scl released", int'(sclOut), 1);
    check("R1 ready", int'(ready), 1);
    check("R1 strobes quiet", int'({drvSda, sclRise, sampleSda, startDone, stopDone}), 0);

    // R10 override and R11 monitor
    clearLog();
    normalOp = 1'b0; sclRelease = 1'b0; sdaLevel = 1'b1; sdaOther = 1'b0;
    tick();
    check("R10 scl follows override", int'(sclOut), 0);
    check("R10 not ready", int'(ready), 0);
    check("R11 monitor in override", int'(busMon), 4'b1000);
    cmdValid = 1'b1; cmdKind = 2'd1;
    repeat (30) tick();
    sclRelease = 1'b1;
    tick();
    check("R10 scl released in override", int'(sclOut), 1);
    check("R11 monitor scl bits", int'(busMon), 4'b1011);
    cmdValid = 1'b0;
    normalOp = 1'b1; sdaOther = 1'b1; sdaLevel = 1'b0;
    tick();
    check("R10 strobes ignored", nDrv + nRise + nSample + nStart + nStop, 0);
    check("R10 ready after override", int'(ready), 1);
    check("R11 monitor sda bits", int'(busMon), 4'b0011);
    sdaLevel = 1'b1;

    for (int i = 0; i < 24; i++) begin
      case (i)
        0: setCfg(20, 11, 10, 2);
        1: setCfg(3, 5, 4, 1);       // period below low + 2
        2: setCfg(30, 12, 0, 0);     // zero edge and data counts
        3: setCfg(25, 6, 3, 60);     // data delay past the low time
        4: setCfg(127, 100, 63, 7);  // top of the count range
        5: setCfg(0, 0, 1, 0);       // everything minimal
        default: setCfg(int'($urandom_range(4, 90)), int'($urandom_range(0, 50)),
                        int'($urandom_range(0, 40)), int'($urandom_range(0, 20)));
      endcase
      doStartIdle();
      for (int b = 0; b < 3; b++) doBit(int'($urandom_range(0, 3)), 2'(b == 2 ? 3 : 0));
      doRestart(0);
      doBit(int'($urandom_range(0, 3)), 2'd0);
      doStop(int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

endmodule